// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block generates data addresses from four pointer registers. An access request selects a pointer and, independently, one of four step registers. The block issues that pointer's current value as the address. In the same clock edge it moves the stored pointer by the signed step. Each pointer has its own buffer length and buffer start registers. A non-zero length keeps the moved pointer inside a circular window. A zero length lets the pointer run linearly and wrap only at the 14-bit address limit.

An output-only bit-reversal mode supports the reordered address sequences that radix-2 FFT passes need. In that mode the issued address has its bits mirrored, while the stored pointer still advances normally. The surrounding logic loads the registers through one write port. It can read any pointer back, before its next update, through a combinational readback port.

The design is a pipeline with a single register stage; it has no state machine. The issued address and its valid flag are registered, so an address appears one cycle after its request.

Top module: `cbuf_agen`

## Requirements
- R1: After reset, every pointer, step, length and start register reads zero, and `addr_valid` is low.
- R2: A write with `wr_en` high stores `wr_data` into register `wr_sel` of the class picked by `wr_kind` (0 = pointer, 1 = step, 2 = length, 3 = buffer start). `rd_index` shows pointer `rd_sel` combinationally.
- R3: When `acc_en` is sampled high, `addr_valid` is high in the next cycle. When `acc_en` is sampled low, `addr_valid` is low in the next cycle.
- R4: The issued address is the selected pointer's value before the update. Any step register may be paired with any pointer.
- R5: With length zero, the pointer becomes (pointer + step) modulo 2^14. The step is a signed two's-complement value.
- R6: With a non-zero length L and start S, a positive step gives the new pointer S + ((pointer − S + step) mod L).
- R7: The same circular formula holds for a negative step whose magnitude is below L, so the pointer wraps back to the top of the window.
- R8: With `brev_en` high, the issued address has bit k equal to bit 13−k of the pointer. The stored pointer is updated exactly as without reversal.
- R9: A pointer write and an access to the same pointer in one cycle: the address is still the old pointer, and the written value is stored. An access to a different pointer in that cycle updates normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register class: 0 pointer, 1 step, 2 length, 3 start |
| wr_sel | input | 2 | Register number within the class |
| wr_data | input | 14 | Value to write |
| acc_en | input | 1 | Access request |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_mod | input | 2 | Step register used by the access |
| brev_en | input | 1 | Bit-reverse the issued address |
| rd_sel | input | 2 | Pointer shown on readback |
| rd_index | output | 14 | Current value of pointer `rd_sel` |
| addr_valid | output | 1 | `addr_out` holds a new address |
| addr_out | output | 14 | Issued address |

## Verification
The bench steps pointers across the ends of their windows in both directions. A design that compared against the length before adding the step, or that took a modulo of a negative sum without correction, would land outside the window or one step off. It also wraps linear pointers past 0 and 16383, which exposes a step that is zero-extended instead of sign-extended. Same-cycle write/access collisions catch a design where the update overrides the write, or where the issued address shows the new value. Reversal mode is checked both at the address output and at the readback port, so reversing the stored pointer is caught.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;
    typedef enum logic [1:0] {
        RK_INDEX  = 2'd0,
        RK_MODIFY = 2'd1,
        RK_LENGTH = 2'd2,
        RK_BASE   = 2'd3
    } regkind_e;
endpackage

// File: rtl/cbuf_agen_regs.sv
module cbuf_agen_regs
    import cbuf_agen_pkg::*;
#(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    localparam int SW  = $clog2(NPTR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  regkind_e                 wr_kind,
    input  logic [SW-1:0]            wr_sel,
    input  logic [AW-1:0]            wr_data,
    input  logic                     upd_en,
    input  logic [SW-1:0]            upd_sel,
    input  logic [AW-1:0]            upd_val,
    output logic [NPTR-1:0][AW-1:0]  idx_q,
    output logic [NPTR-1:0][AW-1:0]  mod_q,
    output logic [NPTR-1:0][AW-1:0]  len_q,
    output logic [NPTR-1:0][AW-1:0]  base_q
);
    for (genvar g = 0; g < NPTR; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_sel == SW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q[g] <= '0;
            end else if (hit && wr_kind == RK_INDEX) begin
                idx_q[g] <= wr_data;
            end else if (upd_en && upd_sel == SW'(g)) begin
                idx_q[g] <= upd_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mod_q[g]  <= '0;
                len_q[g]  <= '0;
                base_q[g] <= '0;
            end else if (hit) begin
                unique case (wr_kind)
                    RK_MODIFY: mod_q[g]  <= wr_data;
                    RK_LENGTH: len_q[g]  <= wr_data;
                    RK_BASE:   base_q[g] <= wr_data;
                    default:   ;
                endcase
            end
        end
    end

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == RK_INDEX) |=> idx_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/cbuf_agen_wrap.sv
module cbuf_agen_wrap #(
    parameter int AW = 14,
    localparam int EW = AW + 2
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0]        off;
    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] lim;
    logic signed [EW-1:0] fixd;

    always_comb begin
        off  = cur - base;
        sum  = $signed({2'b00, off}) + $signed({{2{step[AW-1]}}, step});
        lim  = $signed({2'b00, len});
        fixd = sum;
        if (sum < 0) begin
            fixd = sum + lim;
        end else if (sum >= lim) begin
            fixd = sum - lim;
        end
        if (len == '0) begin
            nxt = cur + step;
        end else begin
            nxt = base + fixd[AW-1:0];
        end
    end
endmodule

// File: rtl/cbuf_agen_brev.sv
module cbuf_agen_brev #(
    parameter int AW     = 14,
    parameter bit ENABLE = 1'b1
) (
    input  logic          en,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    if (ENABLE) begin : g_rev
        logic [AW-1:0] mirrored;
        for (genvar k = 0; k < AW; k++) begin : g_bit
            assign mirrored[k] = din[AW-1-k];
        end
        assign dout = en ? mirrored : din;
    end else begin : g_pass
        logic unused_en;
        assign unused_en = en;
        assign dout      = din;
    end
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
    import cbuf_agen_pkg::*;
#(
    parameter int AW       = 14,
    parameter int NPTR     = 4,
    parameter bit HAS_BREV = 1'b1,
    localparam int SW      = $clog2(NPTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_kind,
    input  logic [SW-1:0] wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_en,
    input  logic [SW-1:0] acc_ptr,
    input  logic [SW-1:0] acc_mod,
    input  logic          brev_en,
    input  logic [SW-1:0] rd_sel,
    output logic [AW-1:0] rd_index,
    output logic          addr_valid,
    output logic [AW-1:0] addr_out
);
    logic [NPTR-1:0][AW-1:0] idx_q, mod_q, len_q, base_q;
    logic [AW-1:0] cur, nxt, issued;
    regkind_e      kind;

    assign kind = regkind_e'(wr_kind);
    assign cur  = idx_q[acc_ptr];

    cbuf_agen_regs #(.AW(AW), .NPTR(NPTR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_kind(kind), .wr_sel(wr_sel), .wr_data(wr_data),
        .upd_en(acc_en), .upd_sel(acc_ptr), .upd_val(nxt),
        .idx_q(idx_q), .mod_q(mod_q), .len_q(len_q), .base_q(base_q)
    );

    cbuf_agen_wrap #(.AW(AW)) u_wrap (
        .cur(cur), .step(mod_q[acc_mod]), .len(len_q[acc_ptr]),
        .base(base_q[acc_ptr]), .nxt(nxt)
    );

    cbuf_agen_brev #(.AW(AW), .ENABLE(HAS_BREV)) u_brev (
        .en(brev_en), .din(cur), .dout(issued)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= acc_en;
            if (acc_en) addr_out <= issued;
        end
    end

    assign rd_index = idx_q[rd_sel];

    // R3
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_valid);
    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !addr_valid);
    // R6
    in_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && len_q[acc_ptr] != '0 && (cur - base_q[acc_ptr]) < len_q[acc_ptr]
         && !(wr_en && kind == RK_INDEX && wr_sel == acc_ptr)
         && !(wr_en && kind == RK_BASE && wr_sel == acc_ptr)
         && !(wr_en && kind == RK_LENGTH && wr_sel == acc_ptr))
        |=> (idx_q[$past(acc_ptr)] - base_q[$past(acc_ptr)]) < len_q[$past(acc_ptr)]);
    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && len_q[acc_ptr] == '0 && !(wr_en && kind == RK_INDEX && wr_sel == acc_ptr))
        |=> idx_q[$past(acc_ptr)] == AW'($past(cur) + $past(mod_q[acc_mod])));
endmodule

// File: tb/cbuf_agen_bench.sv
module cbuf_agen_bench;
    localparam int AW = 14;
    logic clk = 0, rst_n = 0;
    logic wr_en = 0, acc_en = 0, brev_en = 0;
    logic [1:0] wr_kind = 0, wr_sel = 0, acc_ptr = 0, acc_mod = 0, rd_sel = 0;
    logic [AW-1:0] wr_data = 0, rd_index, addr_out;
    logic addr_valid;
    int checks = 0, errors = 0;
    int mi[4], mm[4], ml[4], mb[4];
    int expq[$];
    string tagq[$];

    always #5 clk = ~clk;

    cbuf_agen u_cbuf_agen (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_sel(wr_sel), .wr_data(wr_data), .acc_en(acc_en), .acc_ptr(acc_ptr),
        .acc_mod(acc_mod), .brev_en(brev_en), .rd_sel(rd_sel), .rd_index(rd_index),
        .addr_valid(addr_valid), .addr_out(addr_out));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sgn(int v);
        return (v >= 8192) ? v - 16384 : v;
    endfunction

    function automatic int step_model(int p, int m);
        int s, r;
        s = sgn(mm[m]);
        if (ml[p] == 0) return ((mi[p] + s) % 16384 + 16384) % 16384;
        r = ((mi[p] - mb[p] + s) % ml[p] + ml[p]) % ml[p];
        return (mb[p] + r) % 16384;
    endfunction

    function automatic int rev(int v);
        int r = 0;
        for (int k = 0; k < AW; k++) if (v[k]) r |= 1 << (AW - 1 - k);
        return r;
    endfunction

    task automatic wr(int kind, int sel, int data);
        wr_en = 1; wr_kind = kind[1:0]; wr_sel = sel[1:0]; wr_data = data[AW-1:0];
        @(posedge clk); #1;
        wr_en = 0;
        case (kind)
            0: mi[sel] = data; 1: mm[sel] = data; 2: ml[sel] = data; default: mb[sel] = data;
        endcase
    endtask

    task automatic acc(int p, int m, string tag);
        expq.push_back(brev_en ? rev(mi[p]) : mi[p]);
        tagq.push_back(tag);
        acc_en = 1; acc_ptr = p[1:0]; acc_mod = m[1:0];
        @(posedge clk); #1;
        acc_en = 0;
        mi[p] = step_model(p, m);
    endtask

    task automatic peek(int p, int exp, string tag);
        rd_sel = p[1:0]; #1;
        chk(tag, int'(rd_index), exp);
    endtask

    always @(negedge clk) if (rst_n && addr_valid) begin
        if (expq.size() == 0) chk("R3 unexpected valid", 1, 0);
        else chk({tagq.pop_front(), " addr"}, int'(addr_out), expq.pop_front());
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        foreach (mi[i]) begin mi[i] = 0; mm[i] = 0; ml[i] = 0; mb[i] = 0; end
        repeat (3) @(posedge clk); #1;
        // R1: reset state
        chk("R1 valid", int'(addr_valid), 0);
        for (int p = 0; p < 4; p++) peek(p, 0, "R1 index");
        rst_n = 1; @(posedge clk); #1;
        chk("R3 idle valid", int'(addr_valid), 0);

        // R2 writes and readback
        wr(0, 0, 100); peek(0, 100, "R2 index write");
        wr(1, 0, 3); wr(1, 1, 16384 - 5); wr(1, 2, 4); wr(1, 3, 16384 - 3);

        // R4/R5 linear with various step pairings
        acc(0, 0, "R4 p0m0"); peek(0, 103, "R4 post-modify");
        acc(0, 1, "R4 p0m1"); peek(0, 98, "R5 negative step");
        acc(0, 2, "R4 p0m2"); peek(0, 102, "R4 m2 pairing");
        wr(0, 1, 16383); acc(1, 0, "R5 top"); peek(1, 2, "R5 wrap up");
        wr(0, 1, 1); acc(1, 1, "R5 bottom"); peek(1, 16380, "R5 wrap down");

        // R6 circular positive: start 64, length 10
        wr(3, 2, 64); wr(2, 2, 10); wr(0, 2, 70);
        acc(2, 2, "R6 a"); peek(2, 64, "R6 wrap to start");
        acc(2, 2, "R6 b"); acc(2, 2, "R6 c"); peek(2, 72, "R6 inside");
        acc(2, 0, "R6 d"); peek(2, 65, "R6 step3 wrap");
        // R7 circular negative
        acc(2, 3, "R7 a"); peek(2, 72, "R7 wrap to top");
        acc(2, 3, "R7 b"); acc(2, 3, "R7 c"); peek(2, 66, "R7 inside");
        // power-of-two window: start 32, length 16
        wr(3, 3, 32); wr(2, 3, 16); wr(0, 3, 47);
        acc(3, 0, "R6 p2 window"); peek(3, 34, "R6 full window wrap");
        acc(3, 1, "R7 p2 window"); peek(3, 45, "R7 full window wrap");

        // R8 bit reverse output only
        brev_en = 1; wr(0, 0, 1);
        acc(0, 0, "R8 rev1"); peek(0, 4, "R8 stored normal");
        acc(0, 0, "R8 rev4");
        brev_en = 0; acc(0, 0, "R8 off"); peek(0, 10, "R8 stored after");

        // R9 collision: write and access same pointer
        expq.push_back(mi[0]); tagq.push_back("R9 old addr");
        wr_en = 1; wr_kind = 0; wr_sel = 0; wr_data = 500;
        acc_en = 1; acc_ptr = 0; acc_mod = 0;
        @(posedge clk); #1; wr_en = 0; acc_en = 0; mi[0] = 500;
        peek(0, 500, "R9 write wins");
        // R9 write one pointer, access another
        expq.push_back(mi[1]); tagq.push_back("R9 other addr");
        wr_en = 1; wr_kind = 0; wr_sel = 0; wr_data = 7;
        acc_en = 1; acc_ptr = 1; acc_mod = 0;
        @(posedge clk); #1; wr_en = 0; acc_en = 0;
        mi[0] = 7; mi[1] = step_model(1, 0);
        peek(0, 7, "R9 written");
        peek(1, mi[1], "R9 other updated");

        repeat (3) @(posedge clk); #1;
        chk("R3 queue drained", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule